// File: doc/BRIEF.md
# Single-Outstanding DMA Transaction Controller

This block sits between a local command queue and a memory directory. It takes one load or store command at a time, turns it into a read or write request toward the directory, and then waits for the one response that finishes it: returned data for a read, an acknowledge for a write. It hands that result back to the command side as a one-cycle completion pulse. Only one transaction is ever in flight. The read and write busy states are kept apart, so each transaction can end only on the response type that belongs to it.

Every request leaves on the request output a fixed number of cycles after its command is taken. That delay is set at build time. The request output has no handshake, so the directory must be able to take a request in any cycle. Responses arrive in order. A response that does not fit the current state is stalled at the response input. A type code that is not defined is consumed and dropped, and a sticky error flag records it. A response line address that differs from the saved request line address sets a second sticky flag.

Top module: `dma_xact_ctrl`

## Requirements
- R1: After synchronous reset the controller is idle. In that state `cmd_ready`=1, and `req_valid`, `rd_done`, `wr_done`, `err_kind`, `err_addr` and `rsp_ready` (with no response offered) are all 0.
- R2: A command is taken in a cycle with `cmd_valid`=1 and `cmd_ready`=1. A `cmd_kind` of 2'b01 (load) makes the controller busy with a read, and 2'b10 (store) makes it busy with a write. While busy, `cmd_ready` is 0 and no further command is taken.
- R3: The controller issues one request per taken load or store. `req_valid` is high for exactly one cycle, `ISSUE_DLY` cycles after the cycle in which the command was taken. `req_kind` is 0 for a read and 1 for a write.
- R4: The request carries the taken command's `paddr`, `laddr`, `len` and `data`, even on a read, and `req_src_id` equals the parameter `SRC_ID`.
- R5: While busy with a read, a response with `rsp_kind`=2'b01 (data) is consumed (`rsp_ready`=1). In the next cycle `rd_done` pulses for one cycle with `rd_data` equal to the response data, and `cmd_ready` returns to 1.
- R6: While busy with a write, a response with `rsp_kind`=2'b10 (acknowledge) is consumed. In the next cycle `wr_done` pulses for one cycle and `cmd_ready` returns to 1.
- R7: A data or acknowledge response that arrives while idle, or whose type does not match the busy kind, is not consumed. `rsp_ready` stays 0 and no completion pulse or state change follows.
- R8: A command with `cmd_kind` 2'b00 or 2'b11 that arrives while idle is consumed and sets the sticky `err_kind`. It issues no request, and the controller stays idle.
- R9: A response with `rsp_kind` 2'b00 or 2'b11 is consumed in any state and sets the sticky `err_kind`. It produces no completion pulse and leaves the state unchanged.
- R10: When a completing response has a `rsp_laddr` that differs from the line address of the outstanding request, the sticky `err_addr` is set. The transaction still completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle; command taken when both are high |
| cmd_kind | input | 2 | 01 load, 10 store, others invalid |
| cmd_paddr | input | PADDR_W | Physical address of command |
| cmd_laddr | input | LADDR_W | Line address of command |
| cmd_len | input | LEN_W | Transfer length |
| cmd_data | input | DATA_W | Data block |
| req_valid | output | 1 | One-cycle request strobe |
| req_kind | output | 1 | 0 read, 1 write |
| req_paddr | output | PADDR_W | Request physical address |
| req_laddr | output | LADDR_W | Request line address |
| req_len | output | LEN_W | Request length |
| req_data | output | DATA_W | Request data block |
| req_src_id | output | ID_W | Requester identifier |
| rsp_valid | input | 1 | Response offered |
| rsp_ready | output | 1 | Response consumed this cycle |
| rsp_kind | input | 2 | 01 data, 10 acknowledge, others invalid |
| rsp_laddr | input | LADDR_W | Response line address |
| rsp_data | input | DATA_W | Response data block |
| rd_done | output | 1 | Read completion pulse |
| rd_data | output | DATA_W | Data of completed read |
| wr_done | output | 1 | Write completion pulse |
| err_kind | output | 1 | Sticky: invalid command or response type seen |
| err_addr | output | 1 | Sticky: response line address mismatch |

## Verification
The bench counts cycles from the command hand-off to the request strobe. A timer that is off by one therefore shows up as a strobe one cycle early or late, and a timer that restarts shows up as a second strobe. It offers an acknowledge to a pending read and responses to an idle controller, and holds them there for several cycles. A design that consumed a mismatched response would pulse a completion early or drop the real data. It also sends undefined type codes to both inputs. A design that treated them as valid would either issue a request or leave the busy state, and one that ignored them altogether would stall the response input. Finally it completes a read with a wrong line address and then runs a correct write, to show that the address error sticks while the transaction still finishes.

// File: rtl/dma_xact_pkg.sv
package dma_xact_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BUSY_RD = 2'd1,
    ST_BUSY_WR = 2'd2
  } xact_state_e;

  localparam logic [1:0] CMD_LOAD  = 2'b01;
  localparam logic [1:0] CMD_STORE = 2'b10;
  localparam logic [1:0] RSP_DATA  = 2'b01;
  localparam logic [1:0] RSP_ACK   = 2'b10;

endpackage

// File: rtl/dma_cmd_decode.sv
module dma_cmd_decode
  import dma_xact_pkg::*;
(
  input  logic [1:0] kind,
  output logic       is_load,
  output logic       is_store,
  output logic       is_bad
);

  always_comb begin
    is_load  = (kind == CMD_LOAD);
    is_store = (kind == CMD_STORE);
    is_bad   = !(is_load || is_store);
  end

endmodule

// File: rtl/dma_rsp_match.sv
module dma_rsp_match
  import dma_xact_pkg::*;
#(
  parameter int LADDR_W = 26
) (
  input  xact_state_e        state,
  input  logic               rsp_valid,
  input  logic [1:0]         rsp_kind,
  input  logic [LADDR_W-1:0] rsp_laddr,
  input  logic [LADDR_W-1:0] saved_laddr,
  output logic               take,
  output logic               fin_rd,
  output logic               fin_wr,
  output logic               bad,
  output logic               addr_miss
);

  logic kind_known;

  always_comb begin
    kind_known = (rsp_kind == RSP_DATA) || (rsp_kind == RSP_ACK);
    bad        = rsp_valid && !kind_known;
    fin_rd     = rsp_valid && (state == ST_BUSY_RD) && (rsp_kind == RSP_DATA);
    fin_wr     = rsp_valid && (state == ST_BUSY_WR) && (rsp_kind == RSP_ACK);
    take       = bad || fin_rd || fin_wr;
    addr_miss  = (fin_rd || fin_wr) && (rsp_laddr != saved_laddr);
  end

endmodule

// File: rtl/dma_issue_timer.sv
module dma_issue_timer #(
  parameter int ISSUE_DLY = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic fire
);

  generate
    if (ISSUE_DLY == 1) begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) fire <= 1'b0;
        else     fire <= start;
      end
    end else begin : g_count
      localparam int CW = $clog2(ISSUE_DLY);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (rst) begin
          cnt  <= '0;
          fire <= 1'b0;
        end else begin
          fire <= (cnt == CW'(1));
          if (start)            cnt <= CW'(ISSUE_DLY - 1);
          else if (cnt != '0)   cnt <= cnt - CW'(1);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dma_xact_ctrl.sv
module dma_xact_ctrl
  import dma_xact_pkg::*;
#(
  parameter int              PADDR_W   = 32,
  parameter int              LADDR_W   = 26,
  parameter int              LEN_W     = 8,
  parameter int              DATA_W    = 64,
  parameter int              ID_W      = 4,
  parameter logic [ID_W-1:0] SRC_ID    = 4'h5,
  parameter int              ISSUE_DLY = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_kind,
  input  logic [PADDR_W-1:0] cmd_paddr,
  input  logic [LADDR_W-1:0] cmd_laddr,
  input  logic [LEN_W-1:0]   cmd_len,
  input  logic [DATA_W-1:0]  cmd_data,
  output logic               req_valid,
  output logic               req_kind,
  output logic [PADDR_W-1:0] req_paddr,
  output logic [LADDR_W-1:0] req_laddr,
  output logic [LEN_W-1:0]   req_len,
  output logic [DATA_W-1:0]  req_data,
  output logic [ID_W-1:0]    req_src_id,
  input  logic               rsp_valid,
  output logic               rsp_ready,
  input  logic [1:0]         rsp_kind,
  input  logic [LADDR_W-1:0] rsp_laddr,
  input  logic [DATA_W-1:0]  rsp_data,
  output logic               rd_done,
  output logic [DATA_W-1:0]  rd_data,
  output logic               wr_done,
  output logic               err_kind,
  output logic               err_addr
);

  xact_state_e state;
  logic is_load, is_store, is_bad;
  logic accept, start;
  logic fin_rd, fin_wr, rsp_bad, addr_miss;

  dma_cmd_decode u_dec (
    .kind     (cmd_kind),
    .is_load  (is_load),
    .is_store (is_store),
    .is_bad   (is_bad)
  );

  dma_rsp_match #(.LADDR_W(LADDR_W)) u_match (
    .state       (state),
    .rsp_valid   (rsp_valid),
    .rsp_kind    (rsp_kind),
    .rsp_laddr   (rsp_laddr),
    .saved_laddr (req_laddr),
    .take        (rsp_ready),
    .fin_rd      (fin_rd),
    .fin_wr      (fin_wr),
    .bad         (rsp_bad),
    .addr_miss   (addr_miss)
  );

  dma_issue_timer #(.ISSUE_DLY(ISSUE_DLY)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .fire  (req_valid)
  );

  assign cmd_ready  = (state == ST_IDLE);
  assign accept     = cmd_valid && cmd_ready;
  assign start      = accept && !is_bad;
  assign req_src_id = SRC_ID;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rd_done  <= 1'b0;
      wr_done  <= 1'b0;
      err_kind <= 1'b0;
      err_addr <= 1'b0;
    end else begin
      rd_done <= fin_rd;
      wr_done <= fin_wr;
      if (start)                 state <= is_load ? ST_BUSY_RD : ST_BUSY_WR;
      else if (fin_rd || fin_wr) state <= ST_IDLE;
      if ((accept && is_bad) || rsp_bad) err_kind <= 1'b1;
      if (addr_miss)                     err_addr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (start) begin
      req_kind  <= is_store;
      req_paddr <= cmd_paddr;
      req_laddr <= cmd_laddr;
      req_len   <= cmd_len;
      req_data  <= cmd_data;
    end
    if (fin_rd) rd_data <= rsp_data;
  end

endmodule

// File: rtl/dma_xact_chk.sv
module dma_xact_chk
  import dma_xact_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [1:0] cmd_kind,
  input logic       req_valid,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [1:0] rsp_kind,
  input logic       rd_done,
  input logic       wr_done,
  input logic       err_kind,
  input logic       err_addr
);

  AST_TAKE_MAKES_BUSY: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && (cmd_kind == CMD_LOAD || cmd_kind == CMD_STORE) |=> !cmd_ready); // R2

  AST_REQ_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid); // R3

  AST_RD_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready && rsp_kind == RSP_DATA |=> rd_done && cmd_ready && !wr_done); // R5

  AST_WR_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_ready && rsp_kind == RSP_ACK |=> wr_done && cmd_ready && !rd_done); // R6

  AST_IDLE_HOLDS_RSP: assert property (@(posedge clk) disable iff (rst)
    cmd_ready && rsp_valid && (rsp_kind == RSP_DATA || rsp_kind == RSP_ACK) |-> !rsp_ready); // R7

  AST_BAD_CMD_DROPPED: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && (cmd_kind == 2'b00 || cmd_kind == 2'b11) |=> cmd_ready && err_kind); // R8

  AST_BAD_RSP_TAKEN: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && (rsp_kind == 2'b00 || rsp_kind == 2'b11) |-> rsp_ready); // R9

  AST_KIND_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_kind |=> err_kind); // R9

  AST_ADDR_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_addr |=> err_addr); // R10

endmodule

bind dma_xact_ctrl dma_xact_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_kind  (cmd_kind),
  .req_valid (req_valid),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_kind  (rsp_kind),
  .rd_done   (rd_done),
  .wr_done   (wr_done),
  .err_kind  (err_kind),
  .err_addr  (err_addr)
);

// File: tb/test_dma_xact_ctrl.sv
module test_dma_xact_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 6;
  localparam int PW = 32, LW = 26, NW = 8, DW = 64, IW = 4;
  localparam logic [IW-1:0] SRC = 4'h5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_kind = 2'b00;
  logic [PW-1:0] cmd_paddr = '0;
  logic [LW-1:0] cmd_laddr = '0;
  logic [NW-1:0] cmd_len = '0;
  logic [DW-1:0] cmd_data = '0;
  logic          req_valid, req_kind;
  logic [PW-1:0] req_paddr;
  logic [LW-1:0] req_laddr;
  logic [NW-1:0] req_len;
  logic [DW-1:0] req_data;
  logic [IW-1:0] req_src_id;
  logic          rsp_valid = 1'b0;
  logic          rsp_ready;
  logic [1:0]    rsp_kind = 2'b00;
  logic [LW-1:0] rsp_laddr = '0;
  logic [DW-1:0] rsp_data = '0;
  logic          rd_done, wr_done, err_kind, err_addr;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  dma_xact_ctrl #(.PADDR_W(PW), .LADDR_W(LW), .LEN_W(NW), .DATA_W(DW), .ID_W(IW),
                  .SRC_ID(SRC), .ISSUE_DLY(DLY)) i_dma_xact_ctrl (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
    .cmd_paddr(cmd_paddr), .cmd_laddr(cmd_laddr), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .req_valid(req_valid), .req_kind(req_kind), .req_paddr(req_paddr),
    .req_laddr(req_laddr), .req_len(req_len), .req_data(req_data), .req_src_id(req_src_id),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_kind(rsp_kind),
    .rsp_laddr(rsp_laddr), .rsp_data(rsp_data),
    .rd_done(rd_done), .rd_data(rd_data), .wr_done(wr_done),
    .err_kind(err_kind), .err_addr(err_addr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cmd_valid = 1'b0; rsp_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check_eq("R1 cmd_ready", 64'(cmd_ready), 64'd1);
    check_eq("R1 req_valid", 64'(req_valid), 64'd0);
    check_eq("R1 rd_done",   64'(rd_done),   64'd0);
    check_eq("R1 wr_done",   64'(wr_done),   64'd0);
    check_eq("R1 err_kind",  64'(err_kind),  64'd0);
    check_eq("R1 err_addr",  64'(err_addr),  64'd0);
    check_eq("R1 rsp_ready", 64'(rsp_ready), 64'd0);
  endtask

  task automatic send_cmd(input logic [1:0] k, input logic [PW-1:0] pa,
                          input logic [LW-1:0] la, input logic [NW-1:0] n,
                          input logic [DW-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_paddr = pa; cmd_laddr = la; cmd_len = n; cmd_data = d;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
  endtask

  task automatic watch_req(input logic wk, input logic [PW-1:0] pa,
                           input logic [LW-1:0] la, input logic [NW-1:0] n,
                           input logic [DW-1:0] d);
    for (int i = 1; i <= DLY; i++) begin
      @(negedge clk);
      if (i == 1) check_eq("R2 busy blocks cmd", 64'(cmd_ready), 64'd0);
      if (i < DLY) check_eq("R3 req early", 64'(req_valid), 64'd0);
      else begin
        check_eq("R3 req on time", 64'(req_valid), 64'd1);
        check_eq("R3 req_kind",    64'(req_kind),  64'(wk));
        check_eq("R4 paddr",       64'(req_paddr), 64'(pa));
        check_eq("R4 laddr",       64'(req_laddr), 64'(la));
        check_eq("R4 len",         64'(req_len),   64'(n));
        check_eq("R4 data",        req_data,       d);
        check_eq("R4 src id",      64'(req_src_id), 64'(SRC));
      end
    end
    @(negedge clk);
    check_eq("R3 single pulse", 64'(req_valid), 64'd0);
  endtask

  task automatic finish_rsp(input logic [1:0] k, input logic [LW-1:0] la, input logic [DW-1:0] d);
    @(negedge clk);
    rsp_valid = 1'b1; rsp_kind = k; rsp_laddr = la; rsp_data = d;
    #1 check_eq("R5/R6 rsp taken", 64'(rsp_ready), 64'd1);
    @(posedge clk);
    #1 rsp_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_read();
    do_reset();
    send_cmd(2'b01, 32'h1000_0040, 26'h040_0001, 8'd64, 64'hDEAD_BEEF_0123_4567);
    watch_req(1'b0, 32'h1000_0040, 26'h040_0001, 8'd64, 64'hDEAD_BEEF_0123_4567);
    finish_rsp(2'b01, 26'h040_0001, 64'hCAFE_F00D_8899_AABB);
    check_eq("R5 rd_done",  64'(rd_done), 64'd1);
    check_eq("R5 rd_data",  rd_data, 64'hCAFE_F00D_8899_AABB);
    check_eq("R5 ready",    64'(cmd_ready), 64'd1);
    check_eq("R5 no wr",    64'(wr_done), 64'd0);
    check_eq("R10 no addr err", 64'(err_addr), 64'd0);
    @(negedge clk);
    check_eq("R5 pulse ends", 64'(rd_done), 64'd0);
  endtask

  task automatic t_write();
    do_reset();
    send_cmd(2'b10, 32'h2222_0080, 26'h088_8002, 8'd32, 64'h0F0F_1234_5678_9ABC);
    cmd_valid = 1'b1; cmd_kind = 2'b01; cmd_laddr = 26'h3FF_FFFF;
    watch_req(1'b1, 32'h2222_0080, 26'h088_8002, 8'd32, 64'h0F0F_1234_5678_9ABC);
    check_eq("R2 still blocked", 64'(cmd_ready), 64'd0);
    cmd_valid = 1'b0;
    finish_rsp(2'b10, 26'h088_8002, 64'h0);
    check_eq("R6 wr_done", 64'(wr_done), 64'd1);
    check_eq("R6 no rd",   64'(rd_done), 64'd0);
    check_eq("R6 ready",   64'(cmd_ready), 64'd1);
    @(negedge clk);
    check_eq("R6 pulse ends", 64'(wr_done), 64'd0);
  endtask

  task automatic t_mismatch();
    do_reset();
    rsp_valid = 1'b1; rsp_kind = 2'b10; rsp_laddr = 26'h1;
    #1 check_eq("R7 idle ack held", 64'(rsp_ready), 64'd0);
    repeat (2) @(negedge clk);
    check_eq("R7 idle no done", 64'(wr_done), 64'd0);
    check_eq("R7 idle state",   64'(cmd_ready), 64'd1);
    rsp_valid = 1'b0;
    send_cmd(2'b01, 32'h3000_0000, 26'h000_0123, 8'd8, 64'h1111);
    watch_req(1'b0, 32'h3000_0000, 26'h000_0123, 8'd8, 64'h1111);
    rsp_valid = 1'b1; rsp_kind = 2'b10; rsp_laddr = 26'h000_0123; rsp_data = 64'h5A5A;
    for (int i = 0; i < 3; i++) begin
      #1 check_eq("R7 ack on read held", 64'(rsp_ready), 64'd0);
      @(negedge clk);
      check_eq("R7 no wr_done", 64'(wr_done), 64'd0);
      check_eq("R7 still busy", 64'(cmd_ready), 64'd0);
    end
    rsp_kind = 2'b01;
    #1 check_eq("R7 data now taken", 64'(rsp_ready), 64'd1);
    @(posedge clk);
    #1 rsp_valid = 1'b0;
    @(negedge clk);
    check_eq("R7 read completes", 64'(rd_done), 64'd1);
    check_eq("R7 data", rd_data, 64'h5A5A);
  endtask

  task automatic t_bad_cmd();
    do_reset();
    cmd_valid = 1'b1; cmd_kind = 2'b11;
    #1 check_eq("R8 bad cmd taken", 64'(cmd_ready), 64'd1);
    @(posedge clk);
    #1 cmd_kind = 2'b00;
    @(posedge clk);
    #1 cmd_valid = 1'b0;
    @(negedge clk);
    check_eq("R8 err_kind", 64'(err_kind), 64'd1);
    check_eq("R8 stays idle", 64'(cmd_ready), 64'd1);
    for (int i = 0; i < DLY + 2; i++) begin
      @(negedge clk);
      check_eq("R8 no request", 64'(req_valid), 64'd0);
    end
    send_cmd(2'b10, 32'h4000_0010, 26'h0AB_CDEF, 8'd4, 64'h77);
    watch_req(1'b1, 32'h4000_0010, 26'h0AB_CDEF, 8'd4, 64'h77);
    check_eq("R8 err sticky", 64'(err_kind), 64'd1);
  endtask

  task automatic t_bad_rsp();
    do_reset();
    send_cmd(2'b01, 32'h5000_0000, 26'h155_5555, 8'd16, 64'h99);
    watch_req(1'b0, 32'h5000_0000, 26'h155_5555, 8'd16, 64'h99);
    rsp_valid = 1'b1; rsp_kind = 2'b11; rsp_laddr = 26'h155_5555;
    #1 check_eq("R9 bad rsp taken", 64'(rsp_ready), 64'd1);
    @(posedge clk);
    #1 rsp_valid = 1'b0;
    @(negedge clk);
    check_eq("R9 err_kind",  64'(err_kind), 64'd1);
    check_eq("R9 no rd_done", 64'(rd_done), 64'd0);
    check_eq("R9 still busy", 64'(cmd_ready), 64'd0);
    finish_rsp(2'b01, 26'h155_5555, 64'hABCD);
    check_eq("R9 read after", 64'(rd_done), 64'd1);
  endtask

  task automatic t_addr();
    do_reset();
    send_cmd(2'b01, 32'h6000_0000, 26'h0C0_0C0C, 8'd2, 64'h42);
    watch_req(1'b0, 32'h6000_0000, 26'h0C0_0C0C, 8'd2, 64'h42);
    finish_rsp(2'b01, 26'h0C0_0C0D, 64'h4242);
    check_eq("R10 still completes", 64'(rd_done), 64'd1);
    check_eq("R10 err_addr",        64'(err_addr), 64'd1);
    check_eq("R10 no kind err",     64'(err_kind), 64'd0);
    send_cmd(2'b10, 32'h6000_0040, 26'h0C0_0C10, 8'd2, 64'h43);
    watch_req(1'b1, 32'h6000_0040, 26'h0C0_0C10, 8'd2, 64'h43);
    finish_rsp(2'b10, 26'h0C0_0C10, 64'h0);
    check_eq("R10 write ok", 64'(wr_done), 64'd1);
    check_eq("R10 err sticky", 64'(err_addr), 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_read();
    t_write();
    t_mismatch();
    t_bad_cmd();
    t_bad_rsp();
    t_addr();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule